// File: doc/BRIEF.md
# Packed Byte Video ALU

This block is a SIMD datapath for pixel work. It treats two 32-bit source words as four unsigned byte lanes or as two signed 16-bit lanes. One registered stage produces either a 32-bit result word or an update to four 16-bit sum-of-absolute-difference accumulators. The byte-lane operations are an add that clips instead of wrapping, a rounding or truncating average, and an absolute difference that feeds the accumulators. Two operations rearrange data and do no arithmetic. The first extracts an unaligned word from the 64-bit pair `{src_a, src_b}` at a byte offset. The second packs the low byte of every halfword into one word.

Operations are issued one per cycle with `in_valid` and a 3-bit `opcode`. Each accepted operation updates the result register, the accumulator register, or neither, on the next rising edge. `out_valid` marks that edge. Instruction decode stays outside the block. A typical use is motion estimation: open a block match with the SAA-new opcode, feed rows with the SAA-accumulate opcode, and read the four partial sums from `acc_o`.

Top module: `pbv_alu`

## Requirements
- R1: After reset is asserted, `res_o`, `acc_o` and `out_valid` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. While `in_valid` is low, `res_o` and `acc_o` hold their values.
- R3: Opcode 0 (byte add) sets each byte lane of `res_o` to the unsigned sum of the matching bytes of `src_a` and `src_b`, clipped to 255.
- R4: Opcode 1 (halfword add) sets each 16-bit lane to the signed sum of the matching halfwords. The sum saturates to 0x7FFF on positive overflow and to 0x8000 on negative overflow.
- R5: Opcode 2 (average) sets each byte lane to (a+b+1)>>1. When `avg_trunc` is 1 it uses (a+b)>>1 instead.
- R6: Opcode 3 (SAA accumulate) adds |a_i-b_i| of byte lane i to accumulator i, which is `acc_o[16*i +: 16]`. The sum saturates at 0xFFFF.
- R7: Opcode 4 (SAA new) loads each accumulator i with |a_i-b_i|, discarding its old value.
- R8: Opcodes 3 and 4 leave `res_o` unchanged. Opcodes 0, 1, 2, 5 and 6 leave `acc_o` unchanged.
- R9: Opcode 5 (align) sets byte j of `res_o` to byte (j+`align_off`) of the 64-bit value {src_a, src_b}. Bytes 0-3 of that value are `src_b`, least significant first.
- R10: Opcode 6 (pack) produces the word {src_a[23:16], src_a[7:0], src_b[23:16], src_b[7:0]}.
- R11: Opcode 7 is a no-op. It changes neither `res_o` nor `acc_o`, and it still raises `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issued this cycle |
| opcode | input | 3 | Operation select (see requirements) |
| avg_trunc | input | 1 | Average truncates instead of rounding |
| align_off | input | 2 | Byte offset for align |
| src_a | input | 32 | First operand, upper word of the align pair |
| src_b | input | 32 | Second operand, lower word of the align pair |
| res_o | output | 32 | Registered result word |
| acc_o | output | 64 | Four 16-bit SAA accumulators, lane 0 lowest |
| out_valid | output | 1 | Result or accumulators updated at the last edge |

## Verification
The bench drives byte pairs whose sums cross 255. A design that wraps would return small values where the correct result is 0xFF. It pushes halfword pairs into both signed overflow directions, where a carry-out-based clip gives the wrong saturation value. Odd sums separate rounding from truncation in the average. A long run of maximal differences drives every accumulator into 0xFFFF, so an accumulator without saturation shows up as wrapping to a small value. Each align offset, together with interleaved SAA and ALU operations and the reserved opcode, catches swapped words, cross-writes between the result and accumulator registers, and a no-op that writes.

// File: rtl/pbv_pkg.sv
package pbv_pkg;
  typedef enum logic [2:0] {
    OP_ADD8U   = 3'd0,
    OP_ADD16S  = 3'd1,
    OP_AVG8    = 3'd2,
    OP_SAA_ACC = 3'd3,
    OP_SAA_NEW = 3'd4,
    OP_ALIGN   = 3'd5,
    OP_PACK    = 3'd6,
    OP_NOP     = 3'd7
  } pbv_op_e;
endpackage

// File: rtl/pbv_byte_lane.sv
// One byte lane: clipping add, average and absolute difference.
module pbv_byte_lane #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              trunc,
  output logic [BYTE_W-1:0] add_clip,
  output logic [BYTE_W-1:0] avg,
  output logic [BYTE_W-1:0] absdiff
);
  logic [BYTE_W:0] sum;
  logic            rnd;

  assign sum      = {1'b0, a} + {1'b0, b};
  assign add_clip = sum[BYTE_W] ? {BYTE_W{1'b1}} : sum[BYTE_W-1:0];
  assign rnd      = ~trunc;
  assign avg      = BYTE_W'((sum + {{BYTE_W{1'b0}}, rnd}) >> 1);
  assign absdiff  = (a >= b) ? (a - b) : (b - a);
endmodule

// File: rtl/pbv_half_sat.sv
// Signed saturating add for one halfword lane.
module pbv_half_sat #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  output logic [HALF_W-1:0] sum_sat
);
  logic [HALF_W:0] sum;
  logic            ovf;

  assign sum = {a[HALF_W-1], a} + {b[HALF_W-1], b};
  assign ovf = sum[HALF_W] ^ sum[HALF_W-1];

  always_comb begin
    if (!ovf)
      sum_sat = sum[HALF_W-1:0];
    else if (sum[HALF_W])
      sum_sat = {1'b1, {(HALF_W-1){1'b0}}};
    else
      sum_sat = {1'b0, {(HALF_W-1){1'b1}}};
  end
endmodule

// File: rtl/pbv_aligner.sv
// Picks LANES consecutive bytes out of a byte string at a byte offset.
module pbv_aligner #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int OFF_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CAT_W = (2*LANES-1)*BYTE_W,
  localparam int OUT_W = LANES*BYTE_W
) (
  input  logic [CAT_W-1:0] cat,
  input  logic [OFF_W-1:0] off,
  output logic [OUT_W-1:0] word
);
  for (genvar j = 0; j < LANES; j++) begin : g_byte
    logic [BYTE_W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int k = 0; k < LANES; k++) begin
        if (off == OFF_W'(k))
          pick = cat[(j+k)*BYTE_W +: BYTE_W];
      end
    end
    assign word[j*BYTE_W +: BYTE_W] = pick;
  end
endmodule

// File: rtl/pbv_sad_acc.sv
// Next value of one SAA accumulator, saturating at all-ones.
module pbv_sad_acc #(
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 16
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [BYTE_W-1:0] diff,
  input  logic              fresh,
  output logic [ACC_W-1:0]  acc_nxt
);
  logic [ACC_W:0] sum;

  assign sum = {1'b0, acc} + {{(ACC_W+1-BYTE_W){1'b0}}, diff};

  always_comb begin
    if (fresh)
      acc_nxt = {{(ACC_W-BYTE_W){1'b0}}, diff};
    else if (sum[ACC_W])
      acc_nxt = {ACC_W{1'b1}};
    else
      acc_nxt = sum[ACC_W-1:0];
  end
endmodule

// File: rtl/pbv_alu.sv
module pbv_alu
  import pbv_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 16,
  localparam int WORD_W = LANES*BYTE_W,
  localparam int HALF_W = 2*BYTE_W,
  localparam int HALVES = LANES/2,
  localparam int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int ACCS_W = LANES*ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        opcode,
  input  logic              avg_trunc,
  input  logic [OFF_W-1:0]  align_off,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  output logic [WORD_W-1:0] res_o,
  output logic [ACCS_W-1:0] acc_o,
  output logic              out_valid
);
  pbv_op_e op;
  assign op = pbv_op_e'(opcode);

  logic [WORD_W-1:0] add8_w, avg_w, diff_w, add16_w, align_w, pack_w;
  logic [ACCS_W-1:0] acc_upd_w;
  logic              saa_fresh;

  assign saa_fresh = (op == OP_SAA_NEW);

  // byte lanes
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    pbv_byte_lane #(.BYTE_W(BYTE_W)) u_lane (
      .a       (src_a[i*BYTE_W +: BYTE_W]),
      .b       (src_b[i*BYTE_W +: BYTE_W]),
      .trunc   (avg_trunc),
      .add_clip(add8_w[i*BYTE_W +: BYTE_W]),
      .avg     (avg_w[i*BYTE_W +: BYTE_W]),
      .absdiff (diff_w[i*BYTE_W +: BYTE_W])
    );
    pbv_sad_acc #(.BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_acc (
      .acc    (acc_o[i*ACC_W +: ACC_W]),
      .diff   (diff_w[i*BYTE_W +: BYTE_W]),
      .fresh  (saa_fresh),
      .acc_nxt(acc_upd_w[i*ACC_W +: ACC_W])
    );
  end

  // halfword lanes
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    pbv_half_sat #(.HALF_W(HALF_W)) u_half (
      .a      (src_a[h*HALF_W +: HALF_W]),
      .b      (src_b[h*HALF_W +: HALF_W]),
      .sum_sat(add16_w[h*HALF_W +: HALF_W])
    );
    // low byte of each halfword: src_b halves fill the low bytes, src_a the high
    assign pack_w[h*BYTE_W +: BYTE_W]          = src_b[h*HALF_W +: BYTE_W];
    assign pack_w[(h+HALVES)*BYTE_W +: BYTE_W] = src_a[h*HALF_W +: BYTE_W];
  end

  pbv_aligner #(.LANES(LANES), .BYTE_W(BYTE_W)) u_align (
    .cat ({src_a[WORD_W-BYTE_W-1:0], src_b}),
    .off (align_off),
    .word(align_w)
  );

  // next state
  logic [WORD_W-1:0] res_d;
  logic              res_en, acc_en;

  always_comb begin
    res_d  = res_o;
    res_en = 1'b0;
    acc_en = 1'b0;
    if (in_valid) begin
      unique case (op)
        OP_ADD8U:   begin res_d = add8_w;  res_en = 1'b1; end
        OP_ADD16S:  begin res_d = add16_w; res_en = 1'b1; end
        OP_AVG8:    begin res_d = avg_w;   res_en = 1'b1; end
        OP_ALIGN:   begin res_d = align_w; res_en = 1'b1; end
        OP_PACK:    begin res_d = pack_w;  res_en = 1'b1; end
        OP_SAA_ACC,
        OP_SAA_NEW: acc_en = 1'b1;
        OP_NOP:     ;
        default:    ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o     <= '0;
      acc_o     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (res_en) res_o <= res_d;
      if (acc_en) acc_o <= acc_upd_w;
    end
  end
endmodule

// File: rtl/pbv_alu_chk.sv
module pbv_alu_chk #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int ACC_W  = 16,
  localparam int WORD_W = LANES*BYTE_W,
  localparam int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int ACCS_W = LANES*ACC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        opcode,
  input logic [OFF_W-1:0]  align_off,
  input logic [WORD_W-1:0] src_b,
  input logic [WORD_W-1:0] res_o,
  input logic [ACCS_W-1:0] acc_o,
  input logic              out_valid
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_o) && $stable(acc_o)));
  // R8
  saa_res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 3'd3 || opcode == 3'd4)) |=> $stable(res_o));
  // R8
  alu_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode != 3'd3 && opcode != 3'd4) |=> $stable(acc_o));
  // R11
  nop_res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd7) |=> $stable(res_o));
  // R9
  align_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 3'd5 && align_off == '0) |=> (res_o == $past(src_b)));

  for (genvar i = 0; i < LANES; i++) begin : g_acc
    // R6
    acc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 3'd3) |=>
        (acc_o[i*ACC_W +: ACC_W] >= $past(acc_o[i*ACC_W +: ACC_W])));
  end
endmodule

bind pbv_alu pbv_alu_chk #(.LANES(LANES), .BYTE_W(BYTE_W), .ACC_W(ACC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .opcode   (opcode),
  .align_off(align_off),
  .src_b    (src_b),
  .res_o    (res_o),
  .acc_o    (acc_o),
  .out_valid(out_valid)
);

// File: tb/pbv_alu_tb_top.sv
`timescale 1ns/1ps
module pbv_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  opcode;
  logic        avg_trunc;
  logic [1:0]  align_off;
  logic [31:0] src_a, src_b;
  logic [31:0] res_o;
  logic [63:0] acc_o;
  logic        out_valid;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;
  logic [31:0] exp_res;
  logic [63:0] exp_acc;

  always #4 clk = ~clk;

  pbv_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .avg_trunc(avg_trunc), .align_off(align_off), .src_a(src_a), .src_b(src_b),
    .res_o(res_o), .acc_o(acc_o), .out_valid(out_valid)
  );

  function automatic logic [31:0] m_add8(logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      int s = int'(a[8*i +: 8]) + int'(b[8*i +: 8]);
      r[8*i +: 8] = (s > 255) ? 8'hFF : 8'(s);
    end
    return r;
  endfunction

  function automatic logic [31:0] m_add16(logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    for (int h = 0; h < 2; h++) begin
      int s = int'($signed(a[16*h +: 16])) + int'($signed(b[16*h +: 16]));
      if (s > 32767) s = 32767;
      if (s < -32768) s = -32768;
      r[16*h +: 16] = 16'(s);
    end
    return r;
  endfunction

  function automatic logic [31:0] m_avg(logic [31:0] a, logic [31:0] b, logic t);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = 8'((int'(a[8*i +: 8]) + int'(b[8*i +: 8]) + (t ? 0 : 1)) / 2);
    return r;
  endfunction

  function automatic logic [63:0] m_saa(logic [63:0] acc, logic [31:0] a,
                                        logic [31:0] b, bit fresh);
    logic [63:0] r;
    for (int i = 0; i < 4; i++) begin
      int d = int'(a[8*i +: 8]) - int'(b[8*i +: 8]);
      int s;
      if (d < 0) d = -d;
      s = fresh ? d : int'(acc[16*i +: 16]) + d;
      r[16*i +: 16] = (s > 65535) ? 16'hFFFF : 16'(s);
    end
    return r;
  endfunction

  function automatic logic [31:0] m_align(logic [31:0] a, logic [31:0] b, logic [1:0] o);
    logic [63:0] c = {a, b};
    return c[8*o +: 32];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                       logic [1:0] off, logic t, string req);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; src_a = a; src_b = b; align_off = off; avg_trunc = t;
    case (op)
      3'd0: exp_res = m_add8(a, b);
      3'd1: exp_res = m_add16(a, b);
      3'd2: exp_res = m_avg(a, b, t);
      3'd3: exp_acc = m_saa(exp_acc, a, b, 1'b0);
      3'd4: exp_acc = m_saa(exp_acc, a, b, 1'b1);
      3'd5: exp_res = m_align(a, b, off);
      3'd6: exp_res = {a[23:16], a[7:0], b[23:16], b[7:0]};
      default: ;
    endcase
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " res"}, {32'h0, res_o}, {32'h0, exp_res});
    check({req, " acc (R8)"}, acc_o, exp_acc);
    check("R2 out_valid", {63'h0, out_valid}, 64'h1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5EED_0042;
    void'($urandom(seed));
    in_valid = 0; opcode = 0; avg_trunc = 0; align_off = 0; src_a = 0; src_b = 0;
    rst_n = 0;
    exp_res = 0; exp_acc = 0;
    repeat (3) @(negedge clk);
    check("R1 res", {32'h0, res_o}, 64'h0);
    check("R1 acc", acc_o, 64'h0);
    check("R1 out_valid", {63'h0, out_valid}, 64'h0);
    rst_n = 1;

    // directed corners
    issue(3'd0, 32'hFF80_0110, 32'h0180_FF0F, 0, 0, "R3");
    issue(3'd0, 32'h7F00_FEFF, 32'h8000_0101, 0, 0, "R3");
    issue(3'd1, 32'h7FFF_8000, 32'h0001_FFFF, 0, 0, "R4");
    issue(3'd1, 32'h8001_4000, 32'h8001_4000, 0, 0, "R4");
    issue(3'd1, 32'h1234_FFFE, 32'h0001_0001, 0, 0, "R4");
    issue(3'd2, 32'h0103_FF00, 32'h0000_FE01, 0, 0, "R5 round");
    issue(3'd2, 32'h0103_FF00, 32'h0000_FE01, 0, 1, "R5 trunc");
    issue(3'd4, 32'h10FF_0005, 32'h2000_0300, 0, 0, "R7");
    issue(3'd3, 32'h0000_0000, 32'hFFFF_FFFF, 0, 0, "R6");
    for (int o = 0; o < 4; o++)
      issue(3'd5, 32'h8877_6655, 32'h4433_2211, 2'(o), 0, "R9");
    issue(3'd6, 32'hAABB_CCDD, 32'h1122_3344, 0, 0, "R10");
    issue(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R11");

    // idle cycles hold state
    @(negedge clk);
    check("R2 idle out_valid", {63'h0, out_valid}, 64'h0);
    check("R2 idle res", {32'h0, res_o}, {32'h0, exp_res});
    check("R2 idle acc", acc_o, exp_acc);

    // accumulator saturation
    issue(3'd4, 32'h0, 32'h0, 0, 0, "R7 clear");
    for (int k = 0; k < 260; k++)
      issue(3'd3, 32'hFF00_FF00, 32'h00FF_00FF, 0, 0, "R6 sat");
    check("R6 saturated", acc_o, 64'hFFFF_FFFF_FFFF_FFFF);

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [2:0] op = 3'($urandom_range(0, 7));
      issue(op, $urandom, $urandom, 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), "R3-R11 random op");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule